// File: doc/BRIEF.md
# Parcel-Packed Instruction Unpacker

The unpacker sits between an instruction fetch path and a decoder. It accepts 60-bit instruction words, one per program address, and hands out the instructions packed inside them one at a time. Instructions are 15 or 30 bits long. They are packed from the most significant bit downward, so a word holds up to four 15-bit parcels. The length of each instruction follows from its 6-bit opcode, and for one opcode also from its i field. For every instruction the block presents the opcode, the i and j register fields, and either the k field or an 18-bit address. It also presents a length flag and the address of the word it came from.

The block keeps a cursor into the current word, expressed as the number of bits still unread (60, 45, 30 or 15). When a word is used up, the address steps by one, with wraparound over 18 bits, and the next word is requested. A 30-bit instruction can never span two words. If one would start in the last parcel, the block raises an illegal-packing flag and stops there. A flush input restarts the block at a given address from a fresh word.

Top module: `parcel_unpacker`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `parcel_offset` is 60, `at_word_boundary` is 1, `cur_pc` is 0, `ins_valid` and `illegal` are 0, and `word_ready` is 1.
- R2: `word_ready` is high exactly when no word is held. A word is taken on a cycle with `word_valid` and `word_ready` both high and no flush. Its first instruction is offered on `ins_valid` the next cycle.
- R3: With `parcel_offset` = n and bit 59 as the word's MSB, the opcode is bits n-1..n-6, i is n-7..n-9 and j is n-10..n-12. A short instruction gives k = bits n-13..n-15 and address 0. A long instruction gives address = bits n-13..n-30 and k = 0.
- R4: `ins_long` is 1 for the octal opcodes 02-07, 50-52, 60-62 and 70-72, and 0 for every other opcode except 01.
- R5: For opcode 01, `ins_long` is 1 when i is 0 to 3 and 0 when i is 4 to 7.
- R6: An instruction is consumed only on a cycle with `ins_valid` and `ins_ready` both high. Consuming it lowers `parcel_offset` by 15 (short) or 30 (long). While it is not consumed, all instruction outputs hold their values.
- R7: When the offset would reach 0, the word is released, `cur_pc` increments modulo 2^18 (3FFFF wraps to 0), and `parcel_offset` returns to 60.
- R8: A long instruction at `parcel_offset` 15 drives `illegal` high and `ins_valid` low. Both stay that way until a flush.
- R9: `flush` takes priority over everything except reset. On the next cycle `cur_pc` equals the `flush_pc` that was sampled, no word is held (and any word offered on the flush cycle is dropped), and `parcel_offset` is 60.
- R10: `at_word_boundary` is 1 exactly when `parcel_offset` is 60.
- R11: `cur_pc` is the address of the word being requested while `word_ready` is high, and the address of the word supplying the offered instruction while `ins_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Restart at `flush_pc` with a fresh word |
| flush_pc | input | 18 | Restart address |
| word_valid | input | 1 | Fetch side offers a word for `cur_pc` |
| word_data | input | 60 | Offered instruction word, bit 59 first |
| word_ready | output | 1 | Unpacker can take a word |
| cur_pc | output | 18 | Address of the word being fetched or unpacked |
| ins_valid | output | 1 | Decoded instruction is offered |
| ins_ready | input | 1 | Consumer takes the offered instruction |
| ins_opcode | output | 6 | Operation code |
| ins_i | output | 3 | i field |
| ins_j | output | 3 | j field |
| ins_k | output | 3 | k field (short instructions, else 0) |
| ins_addr | output | 18 | Address field (long instructions, else 0) |
| ins_long | output | 1 | 1 for a 30-bit instruction |
| parcel_offset | output | 6 | Bits still unread in the held word |
| at_word_boundary | output | 1 | Offset is 60 |
| illegal | output | 1 | Long instruction found in the last parcel |

## Verification
The bench builds the block with its default parameters: a 60-bit word, 15-bit parcels and an 18-bit address. At these values the four cursor positions, the long-in-last-parcel fault and the address wrap are all reached with short runs. The fetch side replays a small table of random words. Flushes aimed just below the top of the address space push the counter through 3FFFF to 0 many times, and random stalls on both handshakes exercise the hold behaviour. Because opcodes are random, every length class is hit, including opcode 01 with both halves of i.

// File: rtl/pu_pkg.sv
package pu_pkg;

    localparam int WORD_W   = 60;
    localparam int PARCEL_W = 15;
    localparam int PC_W     = 18;
    localparam int OPC_W    = 6;
    localparam int REG_W    = 3;
    localparam int ADDR_W   = 18;
    localparam int SLOTS    = WORD_W / PARCEL_W;
    localparam int OFF_W    = $clog2(WORD_W + 1);

    typedef struct packed {
        logic [OPC_W-1:0]  opcode;
        logic [REG_W-1:0]  fi;
        logic [REG_W-1:0]  fj;
        logic [REG_W-1:0]  fk;
        logic [ADDR_W-1:0] addr;
        logic              is_long;
    } instr_t;

    // Two-parcel instructions: fixed opcode groups plus the low half of opcode 01.
    function automatic logic op_is_long(input logic [OPC_W-1:0] op,
                                        input logic [REG_W-1:0] fi);
        logic r;
        if (op inside {[6'o02:6'o07], [6'o50:6'o52], [6'o60:6'o62], [6'o70:6'o72]})
            r = 1'b1;
        else if (op == 6'o01)
            r = ~fi[REG_W-1];
        else
            r = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/pu_window_select.sv
module pu_window_select
    import pu_pkg::*;
#(
    parameter int W_WORD   = WORD_W,
    parameter int W_PARCEL = PARCEL_W,
    parameter int N_SLOTS  = SLOTS
) (
    input  logic [W_WORD-1:0]            word,
    input  logic [$clog2(N_SLOTS)-1:0]   slot,
    output logic [2*W_PARCEL-1:0]        window
);
    logic [2*W_PARCEL-1:0] cand [N_SLOTS];

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        if (s + 1 < N_SLOTS) begin : g_pair
            assign cand[s] = {word[W_WORD-1-s*W_PARCEL -: W_PARCEL],
                              word[W_WORD-1-(s+1)*W_PARCEL -: W_PARCEL]};
        end else begin : g_last
            assign cand[s] = {word[W_WORD-1-s*W_PARCEL -: W_PARCEL],
                              {W_PARCEL{1'b0}}};
        end
    end

    always_comb window = cand[slot];
endmodule

// File: rtl/pu_field_split.sv
module pu_field_split
    import pu_pkg::*;
#(
    parameter int W_PARCEL = PARCEL_W
) (
    input  logic [2*W_PARCEL-1:0] window,
    output instr_t                ins
);
    localparam int TOP = 2*W_PARCEL;

    logic [OPC_W-1:0] op;
    logic [REG_W-1:0] fi;
    logic             lng;

    always_comb begin
        op  = window[TOP-1 -: OPC_W];
        fi  = window[TOP-1-OPC_W -: REG_W];
        lng = op_is_long(op, fi);
        ins.opcode  = op;
        ins.fi      = fi;
        ins.fj      = window[TOP-1-OPC_W-REG_W -: REG_W];
        ins.fk      = lng ? '0 : window[TOP-1-OPC_W-2*REG_W -: REG_W];
        ins.addr    = lng ? window[ADDR_W-1:0] : '0;
        ins.is_long = lng;
    end
endmodule

// File: rtl/pu_cursor.sv
module pu_cursor
    import pu_pkg::*;
#(
    parameter int W_WORD  = WORD_W,
    parameter int W_PC    = PC_W,
    parameter int N_SLOTS = SLOTS
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         flush,
    input  logic [W_PC-1:0]              flush_pc,
    input  logic                         word_valid,
    input  logic [W_WORD-1:0]            word_data,
    input  logic                         advance,
    input  logic                         step_long,
    output logic                         have_word,
    output logic [W_WORD-1:0]            word_q,
    output logic [$clog2(N_SLOTS)-1:0]   slot_q,
    output logic [W_PC-1:0]              pc_q
);
    localparam int SW = $clog2(N_SLOTS);

    logic [SW:0] nxt;
    assign nxt = {1'b0, slot_q} + (step_long ? (SW+1)'(2) : (SW+1)'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            have_word <= 1'b0;
            word_q    <= '0;
            slot_q    <= '0;
            pc_q      <= '0;
        end else if (flush) begin
            have_word <= 1'b0;
            slot_q    <= '0;
            pc_q      <= flush_pc;
        end else if (!have_word) begin
            if (word_valid) begin
                have_word <= 1'b1;
                word_q    <= word_data;
                slot_q    <= '0;
            end
        end else if (advance) begin
            if (nxt >= (SW+1)'(N_SLOTS)) begin
                have_word <= 1'b0;
                slot_q    <= '0;
                pc_q      <= pc_q + 1'b1;
            end else begin
                slot_q    <= nxt[SW-1:0];
            end
        end
    end
endmodule

// File: rtl/parcel_unpacker.sv
module parcel_unpacker
    import pu_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  flush,
    input  logic [PC_W-1:0]       flush_pc,
    input  logic                  word_valid,
    input  logic [WORD_W-1:0]     word_data,
    output logic                  word_ready,
    output logic [PC_W-1:0]       cur_pc,
    output logic                  ins_valid,
    input  logic                  ins_ready,
    output logic [OPC_W-1:0]      ins_opcode,
    output logic [REG_W-1:0]      ins_i,
    output logic [REG_W-1:0]      ins_j,
    output logic [REG_W-1:0]      ins_k,
    output logic [ADDR_W-1:0]     ins_addr,
    output logic                  ins_long,
    output logic [OFF_W-1:0]      parcel_offset,
    output logic                  at_word_boundary,
    output logic                  illegal
);
    localparam int SW = $clog2(SLOTS);

    logic                have_word;
    logic [WORD_W-1:0]   word_q;
    logic [SW-1:0]       slot_q;
    logic [2*PARCEL_W-1:0] window;
    instr_t              cur;
    logic                crosses;

    pu_cursor #(.W_WORD(WORD_W), .W_PC(PC_W), .N_SLOTS(SLOTS)) u_cursor (
        .clk        (clk),
        .rst        (rst),
        .flush      (flush),
        .flush_pc   (flush_pc),
        .word_valid (word_valid),
        .word_data  (word_data),
        .advance    (ins_valid & ins_ready),
        .step_long  (cur.is_long),
        .have_word  (have_word),
        .word_q     (word_q),
        .slot_q     (slot_q),
        .pc_q       (cur_pc)
    );

    pu_window_select #(.W_WORD(WORD_W), .W_PARCEL(PARCEL_W), .N_SLOTS(SLOTS)) u_window (
        .word   (word_q),
        .slot   (slot_q),
        .window (window)
    );

    pu_field_split #(.W_PARCEL(PARCEL_W)) u_split (
        .window (window),
        .ins    (cur)
    );

    // A two-parcel instruction needs a parcel beyond the current one.
    assign crosses = cur.is_long && (({1'b0, slot_q} + (SW+1)'(2)) > (SW+1)'(SLOTS));

    assign illegal          = have_word & crosses;
    assign ins_valid        = have_word & ~crosses;
    assign word_ready       = ~have_word;
    assign ins_opcode       = cur.opcode;
    assign ins_i            = cur.fi;
    assign ins_j            = cur.fj;
    assign ins_k            = cur.fk;
    assign ins_addr         = cur.addr;
    assign ins_long         = cur.is_long;
    assign parcel_offset    = OFF_W'(WORD_W - int'(slot_q) * PARCEL_W);
    assign at_word_boundary = (slot_q == '0);
endmodule

// File: rtl/pu_checker.sv
module pu_checker
    import pu_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              flush,
    input logic [PC_W-1:0]   flush_pc,
    input logic              word_ready,
    input logic [PC_W-1:0]   cur_pc,
    input logic              ins_valid,
    input logic              ins_ready,
    input logic [OPC_W-1:0]  ins_opcode,
    input logic [ADDR_W-1:0] ins_addr,
    input logic              ins_long,
    input logic [OFF_W-1:0]  parcel_offset,
    input logic              at_word_boundary,
    input logic              illegal
);
    p_offset_grid_r6: assert property (@(posedge clk) disable iff (rst)
        (parcel_offset == 6'd60) || (parcel_offset == 6'd45) ||
        (parcel_offset == 6'd30) || (parcel_offset == 6'd15));

    p_short_step_r6: assert property (@(posedge clk) disable iff (rst)
        ins_valid && ins_ready && !flush && !ins_long && parcel_offset != 6'd15
        |=> parcel_offset == $past(parcel_offset) - 6'd15);

    p_stall_hold_r6: assert property (@(posedge clk) disable iff (rst)
        ins_valid && !ins_ready && !flush
        |=> ins_valid && $stable(ins_opcode) && $stable(ins_addr) && $stable(parcel_offset));

    p_word_end_r7: assert property (@(posedge clk) disable iff (rst)
        ins_valid && ins_ready && !flush &&
        (parcel_offset == 6'd15 || (parcel_offset == 6'd30 && ins_long))
        |=> at_word_boundary && word_ready && cur_pc == $past(cur_pc) + 18'd1);

    p_illegal_blocks_r8: assert property (@(posedge clk) disable iff (rst)
        illegal |-> !ins_valid && parcel_offset == 6'd15);

    p_illegal_sticks_r8: assert property (@(posedge clk) disable iff (rst)
        illegal && !flush |=> illegal);

    p_flush_restart_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> at_word_boundary && word_ready && !ins_valid && cur_pc == $past(flush_pc));

    p_ready_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        word_ready |-> !ins_valid && !illegal);
endmodule

bind parcel_unpacker pu_checker u_pu_checker (
    .clk              (clk),
    .rst              (rst),
    .flush            (flush),
    .flush_pc         (flush_pc),
    .word_ready       (word_ready),
    .cur_pc           (cur_pc),
    .ins_valid        (ins_valid),
    .ins_ready        (ins_ready),
    .ins_opcode       (ins_opcode),
    .ins_addr         (ins_addr),
    .ins_long         (ins_long),
    .parcel_offset    (parcel_offset),
    .at_word_boundary (at_word_boundary),
    .illegal          (illegal)
);

// File: tb/parcel_unpacker_bench.sv
`timescale 1ns/1ps
module parcel_unpacker_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [17:0] flush_pc = '0;
    logic        word_valid = 1'b0;
    logic [59:0] word_data = '0;
    logic        word_ready;
    logic [17:0] cur_pc;
    logic        ins_valid;
    logic        ins_ready = 1'b0;
    logic [5:0]  ins_opcode;
    logic [2:0]  ins_i, ins_j, ins_k;
    logic [17:0] ins_addr;
    logic        ins_long;
    logic [5:0]  parcel_offset;
    logic        at_word_boundary;
    logic        illegal;

    always #5 clk = ~clk;

    parcel_unpacker u_parcel_unpacker (
        .clk(clk), .rst(rst), .flush(flush), .flush_pc(flush_pc),
        .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
        .cur_pc(cur_pc), .ins_valid(ins_valid), .ins_ready(ins_ready),
        .ins_opcode(ins_opcode), .ins_i(ins_i), .ins_j(ins_j), .ins_k(ins_k),
        .ins_addr(ins_addr), .ins_long(ins_long), .parcel_offset(parcel_offset),
        .at_word_boundary(at_word_boundary), .illegal(illegal)
    );

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    logic [59:0] mem [16];

    // reference state
    bit          m_have;
    logic [59:0] m_word;
    int          m_off;
    logic [17:0] m_pc;
    bit          last_flush;
    int          illegal_seen, wrap_seen;

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
        end
    endtask

    function automatic bit long_of(logic [5:0] op, logic [2:0] fi);
        if ((op >= 6'o02 && op <= 6'o07) || (op >= 6'o50 && op <= 6'o52) ||
            (op >= 6'o60 && op <= 6'o62) || (op >= 6'o70 && op <= 6'o72)) return 1'b1;
        if (op == 6'o01) return fi < 3'd4;
        return 1'b0;
    endfunction

    function automatic logic [5:0] fld(logic [59:0] w, int hi_from_off, int width);
        logic [59:0] t;
        t = w >> hi_from_off;
        return 6'(t & ((60'd1 << width) - 1));
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        for (int n = 0; n < 16; n++) mem[n] = {$urandom, $urandom};
        m_have = 0; m_off = 60; m_pc = '0; m_word = '0; last_flush = 0;
        illegal_seen = 0; wrap_seen = 0;

        for (int c = 0; c < 6000; c++) begin
            @(negedge clk);
            begin
                logic [59:0] t;
                logic [5:0]  e_op;
                logic [2:0]  e_i, e_j, e_k;
                logic [17:0] e_addr;
                bit          e_long, e_ill, e_valid;
                e_op = fld(m_word, m_off - 6, 6);
                e_i  = 3'(fld(m_word, m_off - 9, 3));
                e_j  = 3'(fld(m_word, m_off - 12, 3));
                e_long = long_of(e_op, e_i);
                e_ill  = m_have && e_long && m_off == 15;
                e_valid = m_have && !e_ill;
                if (rst) begin
                    check("R1 offset", 64'(parcel_offset), 64'd60);
                    check("R1 boundary", 64'(at_word_boundary), 64'd1);
                    check("R1 pc", 64'(cur_pc), 64'd0);
                    check("R1 valid", 64'(ins_valid), 64'd0);
                    check("R1 illegal", 64'(illegal), 64'd0);
                    check("R1 word_ready", 64'(word_ready), 64'd1);
                end else begin
                    check("R2 ins_valid", 64'(ins_valid), 64'(e_valid));
                    check("R2 word_ready", 64'(word_ready), 64'(!m_have));
                    check(last_flush ? "R9 pc" : "R11 pc", 64'(cur_pc), 64'(m_pc));
                    check(last_flush ? "R9 offset" : "R6 offset", 64'(parcel_offset), 64'(m_off));
                    check("R10 boundary", 64'(at_word_boundary), 64'(m_off == 60));
                    check("R8 illegal", 64'(illegal), 64'(e_ill));
                    if (e_ill) illegal_seen++;
                    if (e_valid) begin
                        if (e_long) begin
                            t = m_word >> (m_off - 30);
                            e_addr = t[17:0]; e_k = '0;
                        end else begin
                            e_k = 3'(fld(m_word, m_off - 15, 3)); e_addr = '0;
                        end
                        check("R3 opcode", 64'(ins_opcode), 64'(e_op));
                        check("R3 i", 64'(ins_i), 64'(e_i));
                        check("R3 j", 64'(ins_j), 64'(e_j));
                        check("R3 k", 64'(ins_k), 64'(e_k));
                        check("R3 addr", 64'(ins_addr), 64'(e_addr));
                        check(e_op == 6'o01 ? "R5 length" : "R4 length", 64'(ins_long), 64'(e_long));
                    end
                end

                // drive next inputs
                rst = (c < 3);
                ins_ready  = ($urandom_range(0, 9) < 7);
                word_valid = ($urandom_range(0, 9) < 6);
                word_data  = word_valid ? mem[m_pc[3:0]] : {$urandom, $urandom};
                flush = !rst && (e_ill ? ($urandom_range(0, 7) == 0) : ($urandom_range(0, 49) == 0));
                case ($urandom_range(0, 2))
                    0: flush_pc = 18'h3FFFE;
                    1: flush_pc = 18'h3FFFF;
                    default: flush_pc = 18'($urandom);
                endcase
                last_flush = flush;

                // reference next state
                if (rst) begin
                    m_have = 0; m_off = 60; m_pc = '0;
                end else if (flush) begin
                    m_have = 0; m_off = 60; m_pc = flush_pc;
                end else if (!m_have) begin
                    if (word_valid) begin m_have = 1; m_word = word_data; m_off = 60; end
                end else if (e_valid && ins_ready) begin
                    m_off -= e_long ? 30 : 15;
                    if (m_off == 0) begin
                        if (m_pc == 18'h3FFFF) wrap_seen++;
                        m_have = 0; m_off = 60; m_pc = m_pc + 18'd1;
                    end
                end
            end
        end
        // coverage of the fault and the wrap (R8, R7)
        check("R8 illegal reached", 64'(illegal_seen > 0), 64'd1);
        check("R7 wrap reached", 64'(wrap_seen > 0), 64'd1);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule